// File: doc/BRIEF.md
# Hotplug slot status register block

This block keeps the slot insertion and removal bookkeeping that firmware polls during hot-plug handling, for a parameterised number of buses with 32 slots each. For every bus it holds three 32-bit masks, one bit per slot:

- **Arrival mask**: slots that have gained a device.
- **Removal-request mask**: slots whose device is asked to leave.
- **Removable mask**: slots that may be ejected.

The platform reports events on a one-event-per-cycle port. It also supplies two static vectors, one bit per slot across all buses: which slots are occupied, and which slots hold a device that must never be ejected.

Firmware works through a 32-bit register port. A bus-select register chooses the bus that the mask registers refer to. Reading the arrival mask normally consumes it. Writing the eject register retires one slot and tells the platform, through a one-cycle eject strobe carrying bus and slot, to tear down the device.

After power-on, or when the platform asks for a sweep, the block walks all buses in order. On each bus it first retires every pending removal request, lowest slot first. It then reloads that bus's removable mask from the occupied and fixed vectors. Tearing down devices, enumerating buses and raising interrupts are left to the surrounding logic.

Top module: `hp_slot_status`

## Requirements
- R1: Register offsets are fixed: arrival mask 0x0, removal-request mask 0x4, eject/feature 0x8, removable mask 0xC, bus select 0x10.
  - An access is accepted only if all three hold: `acc_be` is 4'hF, `acc_addr[1:0]` is 0, and the address is below 0x14.
  - A rejected access changes nothing, and a rejected read returns zero.
  - Writes to 0x0, 0x4 and 0xC are ignored.
- R2: Event kinds are coded as follows:
  - `ev_kind` 1 (hot-add) sets bit `ev_slot` of bus `ev_bus`'s arrival mask.
  - `ev_kind` 2 (removal request) sets that bit in the removal-request mask.
  - `ev_kind` 0 (device present from power-up) and 3 change nothing.
- R3: An accepted read of the arrival mask returns it and clears it in the same cycle, when `legacy_mode` is 0. When `legacy_mode` is 1 the mask keeps its value.
- R4: If a hot-add event and a clearing read of the arrival mask meet in one cycle, the read returns the old mask. The new bit is kept.
- R5: A write of a nonzero value to the eject register acts only on the lowest set bit of the written data.
  - It clears that slot's bit in both the arrival mask and the removal-request mask of the selected bus.
  - One cycle later, `eject_pulse` is high for one cycle, with `eject_bus` and `eject_slot` set. This strobe is suppressed when the slot is both occupied and fixed.
  - Writing zero does nothing.
- R6: An eject write is ignored while the select value is NUM_BUS or larger.
- R7: Sweep behaviour:
  - A sweep starts when reset is released, or on `sweep_req` when no sweep is running.
  - It visits buses 0 to NUM_BUS-1 in order. On each bus it retires pending removal-request bits one per cycle, lowest first, with the same clearing and strobe rules as R5.
  - When a bus has no removal requests left, its removable mask is loaded with the inverse of (occupied AND fixed).
  - Eject writes are ignored while a sweep runs.
- R8: Reading 0x10 returns the full 32-bit value last written to it (0 after reset). Reading 0x8 returns zero.
- R9: While the select value is NUM_BUS or larger, reads of 0x0, 0x4 and 0xC return zero and clear nothing.
- R10: Every read request raises `rd_valid` for one cycle on the next cycle, with `rd_data` valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | 1: arrival-mask reads do not clear |
| sweep_req | input | 1 | Start a removal sweep over all buses |
| ev_valid | input | 1 | Platform event strobe |
| ev_kind | input | 2 | 0 present at power-up, 1 hot-add, 2 removal request |
| ev_bus | input | BUS_W | Bus of the event |
| ev_slot | input | 5 | Slot of the event |
| slot_present | input | NUM_BUS*32 | Occupied flag, bit bus*32+slot |
| slot_fixed | input | NUM_BUS*32 | Never-eject flag, bit bus*32+slot |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 write, 0 read |
| acc_addr | input | ADDR_W | Byte offset |
| acc_be | input | 4 | Byte enables |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Read response data |
| eject_pulse | output | 1 | One-cycle eject command |
| eject_bus | output | BUS_W | Bus of the ejected slot |
| eject_slot | output | 5 | Ejected slot |

## Verification
The hardest situation to reach is a removal sweep that finds pending requests on several buses at once, while an eject write arrives in the middle of it. The bench first builds up removal requests on three buses, some left over from ignored out-of-range ejects. It then raises `sweep_req` and issues an eject write on the very next cycle.

A second corner is a hot-add landing in the same cycle as a clearing read. The bench drives both on one clock edge and checks that the bit survives into the following read.

A behavioural model, updated every cycle, predicts every read response and every eject strobe.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int SLOTS  = 32;
  localparam int SLOT_W = 5;

  typedef enum logic [1:0] {
    EVK_COLD   = 2'd0,
    EVK_ADD    = 2'd1,
    EVK_REMOVE = 2'd2,
    EVK_NONE   = 2'd3
  } ev_kind_e;

  typedef enum logic [2:0] {
    W_UP    = 3'd0,
    W_DOWN  = 3'd1,
    W_EJECT = 3'd2,
    W_RMV   = 3'd3,
    W_SEL   = 3'd4
  } word_e;

  // index of the lowest set bit, 0 for an empty mask
  function automatic logic [SLOT_W-1:0] lowest_slot(input logic [SLOTS-1:0] m);
    lowest_slot = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (m[i]) lowest_slot = SLOT_W'(i);
  endfunction

  function automatic logic [SLOTS-1:0] slot_bit(input logic [SLOT_W-1:0] s);
    slot_bit = SLOTS'(1) << s;
  endfunction
endpackage

// File: rtl/hp_decode.sv
module hp_decode #(
  parameter int ADDR_W    = 8,
  parameter int WIN_BYTES = 20
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output logic              rd_ok,
  output logic              wr_ok,
  output hp_pkg::word_e     word
);
  logic aligned, in_win;

  assign aligned = (addr[1:0] == 2'b00) && (be == 4'hF);
  assign in_win  = addr < ADDR_W'(WIN_BYTES);
  assign word    = hp_pkg::word_e'(addr[4:2]);
  assign rd_ok   = valid && !write && aligned && in_win;
  assign wr_ok   = valid &&  write && aligned && in_win;
endmodule

// File: rtl/hp_bus_masks.sv
module hp_bus_masks
  import hp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] set_up,
  input  logic [SLOTS-1:0] set_dn,
  input  logic [SLOTS-1:0] clr,
  input  logic             rd_clr,
  input  logic             load_rmv,
  input  logic [SLOTS-1:0] rmv_val,
  output logic [SLOTS-1:0] up,
  output logic [SLOTS-1:0] dn,
  output logic [SLOTS-1:0] rmv
);
  logic [SLOTS-1:0] up_keep;

  assign up_keep = rd_clr ? '0 : ~clr;

  // clears first, then sets: an event in the same cycle survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up  <= '0;
      dn  <= '0;
      rmv <= '1;
    end else begin
      up <= (up & up_keep) | set_up;
      dn <= (dn & ~clr) | set_dn;
      if (load_rmv) rmv <= rmv_val;
    end
  end

  AST_UP_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set_up == '0) |=> (up == '0)); // R3
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_up != '0) |=> ((up & $past(set_up)) == $past(set_up))); // R4
  AST_EJECT_CLEARS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0 && (set_dn & clr) == '0) |=> ((dn & $past(clr)) == '0)); // R5
endmodule

// File: rtl/hp_sweep.sv
module hp_sweep #(
  parameter int NUM_BUS = 8,
  parameter int BUS_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      dn_cur,
  output logic             active,
  output logic [BUS_W-1:0] bus,
  output logic             do_eject,
  output logic             do_load
);
  localparam logic [BUS_W-1:0] LAST = BUS_W'(NUM_BUS - 1);

  assign do_eject = active && (dn_cur != '0);
  assign do_load  = active && (dn_cur == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b1;
      bus    <= '0;
    end else if (do_load) begin
      if (bus == LAST) active <= 1'b0;
      else             bus    <= bus + 1'b1;
    end else if (!active && start) begin
      active <= 1'b1;
      bus    <= '0;
    end
  end

  AST_SWEEP_STAYS_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    do_eject |=> (active && $stable(bus))); // R7
  AST_SWEEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (do_load && bus != LAST) |=> (active && bus == $past(bus) + 1'b1)); // R7
endmodule

// File: rtl/hp_slot_status.sv
module hp_slot_status
  import hp_pkg::*;
#(
  parameter int NUM_BUS = 8,
  parameter int ADDR_W  = 8,
  localparam int BUS_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
  localparam int FLAT_W = NUM_BUS * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              legacy_mode,
  input  logic              sweep_req,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [BUS_W-1:0]  ev_bus,
  input  logic [SLOT_W-1:0] ev_slot,
  input  logic [FLAT_W-1:0] slot_present,
  input  logic [FLAT_W-1:0] slot_fixed,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [3:0]        acc_be,
  input  logic [31:0]       acc_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              eject_pulse,
  output logic [BUS_W-1:0]  eject_bus,
  output logic [SLOT_W-1:0] eject_slot
);
  localparam int IDX_W = $clog2(FLAT_W) + 1;

  logic              rd_ok, wr_ok;
  word_e             word;
  logic [31:0]       sel_q;
  logic              sel_ok;
  logic [BUS_W-1:0]  cur;
  logic [SLOTS-1:0]  up_w [NUM_BUS];
  logic [SLOTS-1:0]  dn_w [NUM_BUS];
  logic [SLOTS-1:0]  rmv_w [NUM_BUS];
  logic [FLAT_W-1:0] nr_vec;
  logic              sw_active, sw_eject, sw_load;
  logic [BUS_W-1:0]  sw_bus;
  logic [SLOTS-1:0]  dn_cur;
  logic              reg_ej, ej_fire, ej_nr, rd_up;
  logic [BUS_W-1:0]  ej_bus;
  logic [SLOT_W-1:0] ej_slot;
  logic [IDX_W-1:0]  ej_idx;
  logic [31:0]       rd_next;

  hp_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(20)) u_dec (
    .valid(acc_valid), .write(acc_write), .addr(acc_addr), .be(acc_be),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .word(word)
  );

  assign sel_ok = sel_q < 32'(NUM_BUS);
  assign cur    = sel_q[BUS_W-1:0];
  assign nr_vec = slot_present & slot_fixed;
  assign dn_cur = dn_w[sw_bus];

  hp_sweep #(.NUM_BUS(NUM_BUS), .BUS_W(BUS_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(sweep_req), .dn_cur(dn_cur),
    .active(sw_active), .bus(sw_bus), .do_eject(sw_eject), .do_load(sw_load)
  );

  // eject source: the sweep owns the path while it runs
  assign reg_ej  = wr_ok && (word == W_EJECT) && sel_ok && (acc_wdata != '0);
  assign ej_fire = sw_eject || (reg_ej && !sw_active);
  assign ej_bus  = sw_active ? sw_bus : cur;
  assign ej_slot = lowest_slot(sw_active ? dn_cur : acc_wdata);
  assign ej_idx  = IDX_W'(ej_bus) * IDX_W'(SLOTS) + IDX_W'(ej_slot);
  assign ej_nr   = nr_vec[ej_idx];
  assign rd_up   = rd_ok && (word == W_UP) && sel_ok;

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    logic hit_ev;
    assign hit_ev = ev_valid && (ev_bus == BUS_W'(b));
    hp_bus_masks u_masks (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_up  ((hit_ev && ev_kind == EVK_ADD)    ? slot_bit(ev_slot) : '0),
      .set_dn  ((hit_ev && ev_kind == EVK_REMOVE) ? slot_bit(ev_slot) : '0),
      .clr     ((ej_fire && ej_bus == BUS_W'(b))  ? slot_bit(ej_slot) : '0),
      .rd_clr  (rd_up && !legacy_mode && cur == BUS_W'(b)),
      .load_rmv(sw_load && sw_bus == BUS_W'(b)),
      .rmv_val (~nr_vec[b*SLOTS +: SLOTS]),
      .up      (up_w[b]),
      .dn      (dn_w[b]),
      .rmv     (rmv_w[b])
    );
  end

  always_comb begin
    rd_next = '0;
    if (rd_ok) begin
      case (word)
        W_UP:    rd_next = sel_ok ? up_w[cur]  : '0;
        W_DOWN:  rd_next = sel_ok ? dn_w[cur]  : '0;
        W_RMV:   rd_next = sel_ok ? rmv_w[cur] : '0;
        W_SEL:   rd_next = sel_q;
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      eject_pulse <= 1'b0;
      eject_bus   <= '0;
      eject_slot  <= '0;
    end else begin
      rd_valid    <= acc_valid && !acc_write;
      rd_data     <= rd_next;
      eject_pulse <= ej_fire && !ej_nr;
      if (ej_fire) begin
        eject_bus  <= ej_bus;
        eject_slot <= ej_slot;
      end
      if (wr_ok && word == W_SEL) sel_q <= acc_wdata;
    end
  end

  AST_BAD_ACCESS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !rd_ok) |=> (rd_data == '0)); // R1
  AST_SEL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && word == W_EJECT && !sel_ok && !sw_active) |=> !eject_pulse); // R6
  AST_FEATURE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && word == W_EJECT) |=> (rd_data == '0)); // R8
  AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && !sel_ok && word != W_SEL) |=> (rd_data == '0)); // R9
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid); // R10
  AST_NO_WRITE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid || acc_write) |=> !rd_valid); // R10
endmodule

// File: tb/test_hp_slot_status.sv
module test_hp_slot_status;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic legacy_mode = 1'b0, sweep_req = 1'b0;
  logic ev_valid = 1'b0;
  logic [1:0] ev_kind = 2'd3;
  logic [2:0] ev_bus = '0;
  logic [4:0] ev_slot = '0;
  logic [NB*32-1:0] slot_present = '0, slot_fixed = '0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [7:0] acc_addr = '0;
  logic [3:0] acc_be = 4'hF;
  logic [31:0] acc_wdata = '0;
  logic rd_valid, eject_pulse;
  logic [31:0] rd_data;
  logic [2:0] eject_bus;
  logic [4:0] eject_slot;

  int total = 0, bad = 0, pulse_cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hp_slot_status #(.NUM_BUS(NB), .ADDR_W(8)) i_hp_slot_status (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .sweep_req(sweep_req),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_bus(ev_bus), .ev_slot(ev_slot),
    .slot_present(slot_present), .slot_fixed(slot_fixed),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_be(acc_be), .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .eject_pulse(eject_pulse), .eject_bus(eject_bus), .eject_slot(eject_slot)
  );

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_up [NB], m_dn [NB], m_rmv [NB];
  bit [31:0] m_sel;
  bit        m_act;
  int        m_bus;
  bit        e_rv, e_ej;
  bit [31:0] e_rd;
  int        e_ebus, e_eslot;

  function automatic int first_one(bit [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic bit pinned(int b, int s);
    return slot_present[b*32+s] && slot_fixed[b*32+s];
  endfunction

  task automatic retire(int b, int s);
    m_up[b][s] = 1'b0;
    m_dn[b][s] = 1'b0;
    e_ej = !pinned(b, s);
    e_ebus = b;
    e_eslot = s;
  endtask

  always @(posedge clk) begin : model
    bit ok, was_act;
    int off;
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_up[b] = 0; m_dn[b] = 0; m_rmv[b] = '1;
      end
      m_sel = 0; m_act = 1; m_bus = 0; e_rv = 0; e_ej = 0; e_rd = 0;
    end else begin
      ok  = acc_valid && acc_be == 4'hF && acc_addr[1:0] == 0 && acc_addr < 8'h14;
      off = int'(acc_addr);
      was_act = m_act;
      e_ej = 0;
      e_rv = acc_valid && !acc_write;
      e_rd = 0;
      if (ok && !acc_write) begin
        if (off == 16) e_rd = m_sel;
        else if (m_sel < NB) begin
          if (off == 0) begin
            e_rd = m_up[m_sel];
            if (!legacy_mode) m_up[m_sel] = 0;
          end
          if (off == 4)  e_rd = m_dn[m_sel];
          if (off == 12) e_rd = m_rmv[m_sel];
        end
      end
      if (was_act) begin
        if (m_dn[m_bus] != 0) retire(m_bus, first_one(m_dn[m_bus]));
        else begin
          for (int s = 0; s < 32; s++) m_rmv[m_bus][s] = !pinned(m_bus, s);
          if (m_bus == NB-1) m_act = 0; else m_bus++;
        end
      end else if (ok && acc_write && off == 8 && m_sel < NB && acc_wdata != 0)
        retire(int'(m_sel), first_one(acc_wdata));
      if (!was_act && sweep_req) begin m_act = 1; m_bus = 0; end
      if (ok && acc_write && off == 16) m_sel = acc_wdata;
      if (ev_valid && ev_kind == 2'd1) m_up[ev_bus][ev_slot] = 1'b1;
      if (ev_valid && ev_kind == 2'd2) m_dn[ev_bus][ev_slot] = 1'b1;
    end
  end

  task automatic check(bit cond, string what, longint act, longint exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(rd_valid == e_rv, "R10 model rd_valid", rd_valid, e_rv);
      if (e_rv) check(rd_data == e_rd, "R1 model rd_data", rd_data, e_rd);
      check(eject_pulse == e_ej, "R5 model eject_pulse", eject_pulse, e_ej);
      if (e_ej) begin
        check(eject_bus == 3'(e_ebus), "R5 model eject_bus", eject_bus, e_ebus);
        check(eject_slot == 5'(e_eslot), "R5 model eject_slot", eject_slot, e_eslot);
      end
      if (eject_pulse) pulse_cnt++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic ev(int kind, int b, int s);
    @(negedge clk);
    ev_valid = 1; ev_kind = 2'(kind); ev_bus = 3'(b); ev_slot = 5'(s);
    @(negedge clk);
    ev_valid = 0; ev_kind = 2'd3;
  endtask

  task automatic wr(int a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = 8'(a); acc_wdata = d; acc_be = be;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_be = 4'hF;
  endtask

  task automatic rd_expect(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = 8'(a);
    @(negedge clk);
    acc_valid = 0;
    check(rd_valid && rd_data == exp, tag, rd_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    slot_present[1*32+3] = 1'b1;
    slot_fixed[1*32+3]   = 1'b1;
    slot_fixed[1*32+4]   = 1'b1;   // fixed but empty: stays removable
    repeat (3) @(negedge clk);
    check(rd_valid == 0 && eject_pulse == 0, "R10 reset outputs idle", rd_valid, 0);
    rst_n = 1;
    repeat (12) @(negedge clk);

    wr(16, 1);
    rd_expect(12, 32'hFFFF_FFF7, "R7 removable mask after power-up sweep");
    rd_expect(16, 1, "R8 select read back");

    ev(1, 2, 5); ev(1, 2, 7); ev(2, 2, 9); ev(0, 2, 11);
    wr(16, 2);
    rd_expect(0, 32'hA0, "R2 hot-add bits");
    rd_expect(0, 0, "R3 arrival mask cleared by read");
    rd_expect(4, 32'h200, "R2 removal request bit, cold plug ignored");
    rd_expect(8, 0, "R8 feature word zero");

    legacy_mode = 1;
    ev(1, 2, 1);
    rd_expect(0, 2, "R3 legacy first read");
    rd_expect(0, 2, "R3 legacy read keeps mask");
    legacy_mode = 0;
    rd_expect(0, 2, "R3 clearing read");
    rd_expect(0, 0, "R3 mask now empty");

    ev(1, 2, 5);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = 8'h0;
    ev_valid = 1; ev_kind = 2'd1; ev_bus = 3'd2; ev_slot = 5'd4;
    @(negedge clk);
    acc_valid = 0; ev_valid = 0; ev_kind = 2'd3;
    check(rd_data == 32'h20, "R4 read returns old mask", rd_data, 32'h20);
    rd_expect(0, 32'h10, "R4 same-cycle event kept");

    ev(2, 1, 3); ev(1, 1, 3); ev(2, 1, 6);
    wr(16, 1);
    wr(8, 32'h48);
    check(eject_pulse == 0, "R5 fixed occupied slot gives no strobe", eject_pulse, 0);
    rd_expect(4, 32'h40, "R5 lowest bit only retired");
    rd_expect(0, 0, "R5 arrival bit cleared by eject");
    wr(8, 32'h40);
    check(eject_pulse && eject_slot == 6 && eject_bus == 1, "R5 eject strobe bus1 slot6",
          {eject_bus, eject_slot}, {3'd1, 5'd6});
    rd_expect(4, 0, "R5 removal bit cleared");
    wr(8, 0);
    check(eject_pulse == 0, "R5 zero write no strobe", eject_pulse, 0);

    ev(2, 2, 12);
    wr(16, 8);
    wr(8, 32'h1000);
    check(eject_pulse == 0, "R6 out-of-range eject ignored", eject_pulse, 0);
    rd_expect(16, 8, "R8 select holds 8");
    rd_expect(4, 0, "R9 out-of-range down read zero");
    rd_expect(12, 0, "R9 out-of-range removable read zero");
    wr(16, 32'hFFFF_FFFF);
    rd_expect(16, 32'hFFFF_FFFF, "R8 full 32-bit select");
    rd_expect(0, 0, "R9 out-of-range arrival read zero");
    wr(16, 2);
    rd_expect(4, 32'h1200, "R6 pending bit survives ignored eject");

    wr(16, 5, 4'h3);
    rd_expect(16, 2, "R1 partial byte enable ignored");
    wr(18, 5);
    rd_expect(16, 2, "R1 misaligned write ignored");
    rd_expect(20, 0, "R1 read outside window zero");
    ev(1, 2, 2);
    wr(0, 32'hFFFF_FFFF);
    rd_expect(0, 32'h4, "R1 write to arrival mask ignored");

    ev(2, 0, 2); ev(2, 0, 5); ev(2, 4, 0);
    pulse_cnt = 0;
    @(negedge clk); sweep_req = 1;
    @(negedge clk); sweep_req = 0;
    wr(8, 32'h200);
    repeat (25) @(negedge clk);
    check(pulse_cnt == 5, "R7 sweep strobe count", pulse_cnt, 5);
    rd_expect(4, 0, "R7 bus2 requests swept");
    wr(16, 0);
    rd_expect(4, 0, "R7 bus0 requests swept");
    wr(16, 4);
    rd_expect(4, 0, "R7 bus4 requests swept");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule